// File: doc/BRIEF.md
# Dual-Source Host Output Buffer Arbiter

This block joins two byte producers, a keyboard channel and an auxiliary (pointing device) channel, behind one output buffer that a host reads through a single data port. Each channel owns a small first-in first-out store filled through a one-cycle push strobe. The block derives the "buffer holds data" and "data came from aux" flags, drives copies of both toward the controller's output port, and raises two level interrupt lines. Whether each line may assert depends on bits of the controller's mode byte, which a separate command decoder owns and presents here.

When both channels hold data, the keyboard channel always wins. A host read removes the oldest byte of the winning channel, and the byte appears on the read-data output after the clock edge that took the read. Flags and interrupts are combinational functions of the channel occupancy and the mode byte, so they follow any change within the same cycle. A push into a full channel is discarded and reported by a one-cycle overflow pulse.

Top module: `obuf_arbiter`

## Requirements
- R1: `stat_full` and `oport_full` are high whenever either channel holds at least one byte; they change in the cycle after the push or read edge that changes occupancy.
- R2: `stat_aux` and `oport_aux` are high only while the aux channel holds data and the keyboard channel is empty.
- R3: A host read (`host_rd` high at a clock edge) takes the oldest keyboard byte whenever the keyboard channel is non-empty, and takes an aux byte only when the keyboard channel is empty; the byte is on `rd_data` after that edge.
- R4: `irq_aux` is high exactly when only the aux channel holds data and mode bit 1 is set.
- R5: `irq_kbd` is high exactly when the keyboard channel holds data, mode bit 0 is set and mode bit 4 (keyboard interface off) is clear.
- R6: Each channel returns its bytes in push order and stores up to DEPTH (default 16) bytes.
- R7: A push into a channel that already holds DEPTH bytes is dropped, and that channel's overflow output is high for the one cycle after the edge.
- R8: A host read while both channels are empty leaves `rd_data` and all flags unchanged.
- R9: After reset both channels are empty, all flags, interrupts and overflow outputs are low and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_push | input | 1 | Push strobe, keyboard channel |
| kbd_push_data | input | 8 | Byte to push, keyboard channel |
| aux_push | input | 1 | Push strobe, aux channel |
| aux_push_data | input | 8 | Byte to push, aux channel |
| host_rd | input | 1 | Host data-port read strobe |
| mode_bits | input | 8 | Controller mode byte (bits 0, 1, 4 used) |
| rd_data | output | 8 | Last byte taken by a host read |
| stat_full | output | 1 | Status: output buffer holds data |
| stat_aux | output | 1 | Status: buffered data is from aux |
| oport_full | output | 1 | Output-port copy of the full flag |
| oport_aux | output | 1 | Output-port copy of the aux flag |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Aux interrupt level |
| kbd_ovf | output | 1 | Keyboard push dropped (one cycle) |
| aux_ovf | output | 1 | Aux push dropped (one cycle) |

## Verification
A wrong occupancy count in either channel shows on the very next cycle as a full or aux flag that disagrees with the bytes pushed and read, and as an interrupt line at the wrong level. A misplaced read or write pointer shows at the first host read after it, as a byte out of push order on `rd_data`. A wrong priority choice shows on the first read made while both channels hold data, because an aux byte comes out ahead of a pending keyboard byte. The bench therefore compares every read byte against a model queue and checks all flags after each push and read.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;
   localparam int NSRC        = 2;
   localparam int SRC_KBD     = 0;
   localparam int SRC_AUX     = 1;
   localparam int MODE_W      = 8;
   // mode byte bit positions read by the arbiter
   localparam int MB_KBD_IRQ  = 0;
   localparam int MB_AUX_IRQ  = 1;
   localparam int MB_KBD_OFF  = 4;

   typedef struct packed {
      logic full;
      logic aux_only;
      logic irq_kbd;
      logic irq_aux;
   } route_flags_t;
endpackage

// File: rtl/obuf_byte_fifo.sv
module obuf_byte_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         not_empty,
   output logic         ovf
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("obuf_byte_fifo: DEPTH must be a power of two >= 2");
   end
   if (W < 1) begin : g_bad_width
      $error("obuf_byte_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          full, do_push, do_pop;

   assign full      = (count == CW'(DEPTH));
   assign not_empty = (count != '0);
   assign do_push   = push && !full;
   assign do_pop    = pop && not_empty;
   assign head      = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
      end else begin
         ovf <= push && full;
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R6 / R7: occupancy stays within the store
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_drop_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> (ovf && count == $past(count) - CW'($past(do_pop))));
   assert_pop_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && not_empty && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/obuf_route.sv
module obuf_route
   import obuf_arb_pkg::*;
(
   input  logic [NSRC-1:0]   src_ne,
   input  logic [MODE_W-1:0] mode_bits,
   output route_flags_t      flags,
   output logic              sel_aux
);
   always_comb begin
      sel_aux        = src_ne[SRC_AUX] && !src_ne[SRC_KBD];
      flags.full     = |src_ne;
      flags.aux_only = sel_aux;
      flags.irq_aux  = sel_aux && mode_bits[MB_AUX_IRQ];
      flags.irq_kbd  = src_ne[SRC_KBD] && mode_bits[MB_KBD_IRQ]
                       && !mode_bits[MB_KBD_OFF];
   end
endmodule

// File: rtl/obuf_arbiter.sv
module obuf_arbiter
   import obuf_arb_pkg::*;
#(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kbd_push,
   input  logic [W-1:0]      kbd_push_data,
   input  logic              aux_push,
   input  logic [W-1:0]      aux_push_data,
   input  logic              host_rd,
   input  logic [MODE_W-1:0] mode_bits,
   output logic [W-1:0]      rd_data,
   output logic              stat_full,
   output logic              stat_aux,
   output logic              oport_full,
   output logic              oport_aux,
   output logic              irq_kbd,
   output logic              irq_aux,
   output logic              kbd_ovf,
   output logic              aux_ovf
);
   logic [NSRC-1:0] s_push, s_pop, s_ne, s_ovf;
   logic [W-1:0]    s_wdata [NSRC];
   logic [W-1:0]    s_head  [NSRC];
   route_flags_t    flags;
   logic            sel_aux;

   assign s_push[SRC_KBD]  = kbd_push;
   assign s_push[SRC_AUX]  = aux_push;
   assign s_wdata[SRC_KBD] = kbd_push_data;
   assign s_wdata[SRC_AUX] = aux_push_data;
   assign s_pop[SRC_KBD]   = host_rd && s_ne[SRC_KBD];
   assign s_pop[SRC_AUX]   = host_rd && sel_aux;

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      obuf_byte_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (s_push[g]),
         .push_data (s_wdata[g]),
         .pop       (s_pop[g]),
         .head      (s_head[g]),
         .not_empty (s_ne[g]),
         .ovf       (s_ovf[g])
      );
   end

   obuf_route i_route (
      .src_ne    (s_ne),
      .mode_bits (mode_bits),
      .flags     (flags),
      .sel_aux   (sel_aux)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else if (host_rd && flags.full)
         rd_data <= sel_aux ? s_head[SRC_AUX] : s_head[SRC_KBD];
   end

   assign stat_full  = flags.full;
   assign stat_aux   = flags.aux_only;
   assign oport_full = flags.full;
   assign oport_aux  = flags.aux_only;
   assign irq_kbd    = flags.irq_kbd;
   assign irq_aux    = flags.irq_aux;
   assign kbd_ovf    = s_ovf[SRC_KBD];
   assign aux_ovf    = s_ovf[SRC_AUX];

   assert_aux_in_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_aux |-> (stat_full && s_ne[SRC_AUX]));
   assert_irq_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_aux |-> !irq_kbd);
   assert_kbd_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && s_ne[SRC_KBD]) |=> (rd_data == $past(s_head[SRC_KBD])));
   assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !stat_full && !kbd_push && !aux_push) |=> ($stable(rd_data) && !stat_full));
   assert_kbd_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_kbd |-> (s_ne[SRC_KBD] && !mode_bits[MB_KBD_OFF]));
endmodule

// File: tb/test_obuf_arbiter.sv
module test_obuf_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       kbd_push = 1'b0, aux_push = 1'b0, host_rd = 1'b0;
   logic [7:0] kbd_push_data = '0, aux_push_data = '0, mode_bits = '0;
   logic [7:0] rd_data;
   logic       stat_full, stat_aux, oport_full, oport_aux;
   logic       irq_kbd, irq_aux, kbd_ovf, aux_ovf;

   int n_vec = 0, n_bad = 0;
   logic [7:0] kq[$], aq[$], exp_q[$];
   logic [7:0] last_rd = 8'h00;
   logic       rd_seen = 1'b0;
   string      rd_tag = "R3";

   always #10 clk = ~clk;

   obuf_arbiter i_obuf_arbiter (
      .clk(clk), .rst_n(rst_n),
      .kbd_push(kbd_push), .kbd_push_data(kbd_push_data),
      .aux_push(aux_push), .aux_push_data(aux_push_data),
      .host_rd(host_rd), .mode_bits(mode_bits), .rd_data(rd_data),
      .stat_full(stat_full), .stat_aux(stat_aux),
      .oport_full(oport_full), .oport_aux(oport_aux),
      .irq_kbd(irq_kbd), .irq_aux(irq_aux),
      .kbd_ovf(kbd_ovf), .aux_ovf(aux_ovf));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
      n_vec++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, expv, $time);
      end
   endtask

   // monitor: compare each read result against the scoreboard
   always @(posedge clk) rd_seen <= host_rd;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) chk(rd_tag, rd_data, exp_q.pop_front());
   end

   task automatic check_flags();
      logic kne, ane;
      kne = kq.size() > 0;
      ane = aq.size() > 0;
      chk("R1 stat_full",  {7'b0, stat_full},  {7'b0, kne | ane});
      chk("R1 oport_full", {7'b0, oport_full}, {7'b0, kne | ane});
      chk("R2 stat_aux",   {7'b0, stat_aux},   {7'b0, ane & ~kne});
      chk("R2 oport_aux",  {7'b0, oport_aux},  {7'b0, ane & ~kne});
      chk("R4 irq_aux",    {7'b0, irq_aux},    {7'b0, ane & ~kne & mode_bits[1]});
      chk("R5 irq_kbd",    {7'b0, irq_kbd},    {7'b0, kne & mode_bits[0] & ~mode_bits[4]});
   endtask

   task automatic push_one(input bit aux, input logic [7:0] b);
      bit drop;
      @(negedge clk);
      if (aux) begin
         drop = aq.size() >= 16;
         aux_push = 1'b1; aux_push_data = b;
         if (!drop) aq.push_back(b);
      end else begin
         drop = kq.size() >= 16;
         kbd_push = 1'b1; kbd_push_data = b;
         if (!drop) kq.push_back(b);
      end
      @(negedge clk);
      kbd_push = 1'b0; aux_push = 1'b0;
      chk("R7 ovf", {7'b0, aux ? aux_ovf : kbd_ovf}, {7'b0, drop});
   endtask

   task automatic read_one(input string tag);
      @(negedge clk);
      rd_tag = tag;
      if (kq.size() > 0)      last_rd = kq.pop_front();
      else if (aq.size() > 0) last_rd = aq.pop_front();
      exp_q.push_back(last_rd);
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk("R9 rd_data", rd_data, 8'h00);
      chk("R9 ovf", {6'b0, kbd_ovf, aux_ovf}, 8'h00);
      check_flags();
      chk("R9 irq", {6'b0, irq_kbd, irq_aux}, 8'h00);

      mode_bits = 8'h03;
      push_one(1'b1, 8'h11);            // aux only: aux flag and irq
      check_flags();
      push_one(1'b0, 8'h22);            // kbd takes over (R2, R5)
      push_one(1'b0, 8'h33);
      check_flags();
      mode_bits = 8'h13;                // keyboard interface off (R5)
      @(negedge clk); check_flags();
      mode_bits = 8'h02;                // kbd irq enable clear
      @(negedge clk); check_flags();
      mode_bits = 8'h03;
      read_one("R3 kbd first");
      @(negedge clk); check_flags();
      read_one("R3 kbd first");
      @(negedge clk); check_flags();    // aux alone again
      mode_bits = 8'h01;                // aux irq disabled (R4)
      @(negedge clk); check_flags();
      mode_bits = 8'h03;
      read_one("R3 aux when kbd empty");
      @(negedge clk); check_flags();
      read_one("R8 empty read holds");  // both empty
      @(negedge clk); check_flags();
      chk("R8 rd_data held", rd_data, 8'h11);

      // R6 / R7: fill keyboard beyond capacity, then drain in order
      for (int i = 0; i < 17; i++) push_one(1'b0, 8'h40 + 8'(i));
      check_flags();
      for (int i = 0; i < 4; i++) push_one(1'b1, 8'hA0 + 8'(i));
      for (int i = 0; i < 16; i++) read_one("R6 kbd order");
      @(negedge clk); check_flags();
      push_one(1'b0, 8'h99);            // kbd arrives mid aux drain
      read_one("R3 kbd preempts aux");
      for (int i = 0; i < 4; i++) read_one("R6 aux order");
      // fill aux to capacity plus one
      for (int i = 0; i < 17; i++) push_one(1'b1, 8'hC0 + 8'(i));
      check_flags();
      for (int i = 0; i < 16; i++) read_one("R6 aux order");
      read_one("R8 empty read holds");
      @(negedge clk); check_flags();
      chk("R8 rd_data held", rd_data, 8'hCF);

      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule